// File: doc/BRIEF.md
# Power-Management Event Status Collector

This block gathers power-management events into one status register that software can read, and it drives an active-low request line toward the processor's management-mode input. Four events come from pins: a write to the power-management control port, an external request, and two interrupt lines. A fifth event is raised inside the block by a reloading down-counter, which software uses as an idle timer. Every pin event passes through a two-stage synchronizer and an edge detector. A status bit is set once for each rising edge, never by a level that stays high.

Software reaches three registers through a small port with an address, a write strobe and combinational read data. The status register is cleared by writing zeros. The reload register sets the timer period. The control register holds a per-event enable, a global request gate and a timer stop bit. The request line is low while the gate is set and any enabled status bit is 1.

Top module: `pm_event_collector`

## Requirements
- R1: Reset state: status reads 0000h, reload reads 00FFh, control reads F808h (all enables 1, gate 0, timer stopped), and smiN is 1.
- R2: Status layout at address 0: bit 7 port write, bit 6 external, bit 5 timer, bit 4 interrupt line A, bit 3 interrupt line B. All other bits read 0. A rising pin event becomes visible after the third rising clock edge that follows the input change.
- R3: A bit is set only on a rising edge. An input still held high after software clears its bit does not set it again until the input falls and rises once more.
- R4: Writing to address 0 clears each bit whose data bit is 0. Data bits written as 1 leave their status bits unchanged, so each bit is handled on its own.
- R5: When a hardware set and a software clear reach the same bit on the same clock edge, the bit ends at 1.
- R6: An event sets its status bit only while its enable is 1. Control bits 15..11 enable status bits 7..3 in that order.
- R7: Control bit 0 is the gate. smiN is 0 exactly when the gate is 1 and at least one status bit whose enable is 1 is set. Status bits still set and clear while the gate is 0.
- R8: While control bit 3 is 0, the counter drops by one on each clock with tickEn high. A tick taken at count 1 sets status bit 5 and reloads the count on that edge, so the period is the reload value in ticks. Clocks with tickEn low do not count.
- R9: Address 1 reads back the last accepted reload value, not the live count. A write while the timer runs is ignored, and a written 00h is stored as 01h.
- R10: While control bit 3 is 1, the counter is held at the reload value and never expires. After a restart, the first expiry comes a full reload period later.
- R11: A pin event that is already high when reset is released is detected once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaler tick; the timer counts on clocks where it is high |
| evtApm | input | 1 | Power-management control port write event (active high) |
| evtExt | input | 1 | External request event (active high) |
| evtIrqA | input | 1 | Interrupt line A event (active high) |
| evtIrqB | input | 1 | Interrupt line B event (active high) |
| regAddr | input | 2 | Register select: 0 status, 1 reload, 2 control |
| regWr | input | 1 | Write strobe, applied on the rising clock edge |
| regWdata | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for regAddr |
| smiN | output | 1 | Active-low management interrupt request |

## Verification
Pin events are driven as single-cycle pulses, which shows that each edge sets its own bit at the right position with the exact latency. They are also driven as long levels held across a software clear, which separates edge detection from level detection. A write timed to land on the same edge as a synchronized rising edge tells whether set or clear wins. Writes with mixed ones and zeros show that bits are cleared one by one. The timer runs at several reload values, including the 00h write that maps to a one-tick period. It also runs with ticks withheld, with writes while running, and through a stop part-way into a period, which separates a full reload on restart from a resumed count.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int NUM_EVT  = 5;   // status events
  localparam int NUM_PIN  = NUM_EVT - 1;
  localparam int EVT_LSB  = 3;   // status bit of event 0
  localparam int EN_LSB   = 11;  // control bit of enable 0
  localparam int GATE_BIT = 0;
  localparam int STOP_BIT = 3;

  // event index order, low to high status bit
  localparam int EV_IRQB  = 0;
  localparam int EV_IRQA  = 1;
  localparam int EV_TIMER = 2;
  localparam int EV_EXT   = 3;
  localparam int EV_APM   = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS  = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CONTROL = 2'd2,
    REG_NONE    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              wrStatus;
    logic              wrReload;
    logic [DATA_W-1:0] wdata;
  } hostStrobe_t;
endpackage

// File: rtl/pmev_edge_sync.sv
module pmev_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic evtRaw,
  output logic evtRise
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;  // zero so a high input at reset release counts once
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], evtRaw};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign evtRise = syncQ[SYNC_STAGES-1] & ~prevQ;

  // a detected edge never lasts two cycles
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    evtRise |=> !evtRise);
endmodule

// File: rtl/pmev_timer.sv
module pmev_timer #(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               timerStop,
  input  logic [TIMER_W-1:0] reloadVal,
  output logic               expire
);
  localparam logic [TIMER_W-1:0] CNT_ONE = TIMER_W'(1);

  logic [TIMER_W-1:0] countQ;

  assign expire = !timerStop && tickEn && (countQ == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           countQ <= '1;
    else if (timerStop)  countQ <= reloadVal;
    else if (expire)     countQ <= reloadVal;
    else if (tickEn)     countQ <= countQ - CNT_ONE;
  end

  p_count_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
    countQ != '0);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (countQ == $past(reloadVal)));
  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    timerStop |-> !expire);
endmodule

// File: rtl/pmev_ctrl.sv
module pmev_ctrl
  import pmev_pkg::*;
#(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_EVT-1:0] statusQ,
  input  logic [TIMER_W-1:0] reloadQ,
  output hostStrobe_t        strobe,
  output logic [DATA_W-1:0]  rdData,
  output logic               gate,
  output logic               timerStop,
  output logic [NUM_EVT-1:0] evtEn
);
  logic [NUM_EVT-1:0] enQ;
  logic               gateQ;
  logic               stopQ;
  logic               wrCtrl;

  always_comb begin
    strobe          = '0;
    strobe.wdata    = regWdata;
    strobe.wrStatus = regWr && (regAddr == REG_STATUS);
    strobe.wrReload = regWr && (regAddr == REG_RELOAD);
  end
  assign wrCtrl = regWr && (regAddr == REG_CONTROL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '1;
      gateQ <= 1'b0;
      stopQ <= 1'b1;
    end else if (wrCtrl) begin
      enQ   <= regWdata[EN_LSB +: NUM_EVT];
      gateQ <= regWdata[GATE_BIT];
      stopQ <= regWdata[STOP_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      REG_STATUS:  rdData[EVT_LSB +: NUM_EVT] = statusQ;
      REG_RELOAD:  rdData[TIMER_W-1:0]        = reloadQ;
      REG_CONTROL: begin
        rdData[EN_LSB +: NUM_EVT] = enQ;
        rdData[GATE_BIT]          = gateQ;
        rdData[STOP_BIT]          = stopQ;
      end
      default:     rdData = '0;
    endcase
  end

  assign gate      = gateQ;
  assign timerStop = stopQ;
  assign evtEn     = enQ;

  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> $stable({enQ, gateQ, stopQ}));
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrStatus, strobe.wrReload, wrCtrl}));
endmodule

// File: rtl/pmev_datapath.sv
module pmev_datapath
  import pmev_pkg::*;
#(
  parameter int TIMER_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic [NUM_PIN-1:0] evtPin,
  input  hostStrobe_t        strobe,
  input  logic               timerStop,
  input  logic [NUM_EVT-1:0] evtEn,
  output logic [NUM_EVT-1:0] statusQ,
  output logic [TIMER_W-1:0] reloadQ
);
  localparam logic [TIMER_W-1:0] RELOAD_MIN = TIMER_W'(1);

  logic [NUM_EVT-1:0] evtRise;
  logic [NUM_EVT-1:0] hwSet;
  logic [NUM_EVT-1:0] swKeep;
  logic [TIMER_W-1:0] reloadIn;
  logic               timerExpire;

  pmev_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .timerStop (timerStop),
    .reloadVal (reloadQ),
    .expire    (timerExpire)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    if (i == EV_TIMER) begin : g_tmr
      assign evtRise[i] = timerExpire;
    end else begin : g_pin
      localparam int PIN = (i < EV_TIMER) ? i : i - 1;
      pmev_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rstN    (rstN),
        .evtRaw  (evtPin[PIN]),
        .evtRise (evtRise[i])
      );
    end
  end

  assign hwSet  = evtRise & evtEn;
  assign swKeep = strobe.wrStatus ? strobe.wdata[EVT_LSB +: NUM_EVT] : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= hwSet | (statusQ & swKeep);
  end

  assign reloadIn = (strobe.wdata[TIMER_W-1:0] == '0) ? RELOAD_MIN
                                                     : strobe.wdata[TIMER_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             reloadQ <= '1;
    else if (strobe.wrReload && timerStop) reloadQ <= reloadIn;
  end

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hwSet != '0) |=> ((statusQ & $past(hwSet)) == $past(hwSet)));
  p_sw_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStatus |=>
      ((statusQ & ~$past(hwSet) & ~$past(strobe.wdata[EVT_LSB +: NUM_EVT])) == '0));
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(hwSet)) == '0));
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(evtEn)) == '0));
  p_reload_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrReload && !timerStop) |=> $stable(reloadQ));
  p_reload_nonzero_r9: assert property (@(posedge clk) disable iff (!rstN)
    reloadQ != '0);
endmodule

// File: rtl/pm_event_collector.sv
module pm_event_collector
  import pmev_pkg::*;
#(
  parameter int TIMER_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              evtApm,
  input  logic              evtExt,
  input  logic              evtIrqA,
  input  logic              evtIrqB,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              smiN
);
  hostStrobe_t        strobe;
  logic [NUM_EVT-1:0] statusQ;
  logic [NUM_EVT-1:0] evtEn;
  logic [TIMER_W-1:0] reloadQ;
  logic [NUM_PIN-1:0] evtPin;
  logic               gate;
  logic               timerStop;

  // pin order skips the timer slot of the status layout
  assign evtPin = {evtApm, evtExt, evtIrqA, evtIrqB};

  pmev_ctrl #(.TIMER_W(TIMER_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWdata  (regWdata),
    .statusQ   (statusQ),
    .reloadQ   (reloadQ),
    .strobe    (strobe),
    .rdData    (rdData),
    .gate      (gate),
    .timerStop (timerStop),
    .evtEn     (evtEn)
  );

  pmev_datapath #(.TIMER_W(TIMER_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .evtPin    (evtPin),
    .strobe    (strobe),
    .timerStop (timerStop),
    .evtEn     (evtEn),
    .statusQ   (statusQ),
    .reloadQ   (reloadQ)
  );

  assign smiN = !(gate && ((statusQ & evtEn) != '0));

  p_smi_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !gate |-> smiN);
  p_smi_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    !smiN |-> (statusQ != '0));
endmodule

// File: tb/pm_event_collector_bench.sv
module pm_event_collector_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b1;
  logic        evtApm = 1'b0, evtExt = 1'b0, evtIrqA = 1'b1, evtIrqB = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWr = 1'b0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] rdData;
  logic        smiN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_STAT = 2'd0, A_RLD = 2'd1, A_CTRL = 2'd2;

  pm_event_collector u_pm_event_collector (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .evtApm(evtApm), .evtExt(evtExt), .evtIrqA(evtIrqA), .evtIrqB(evtIrqB),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .rdData(rdData), .smiN(smiN)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic chkReg(input string tag, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic test_reset;
    chk("R1 smiN in reset", {15'h0, smiN}, 16'h0001);
    chkReg("R1 status reset", A_STAT, 16'h0000);
    chkReg("R1 reload reset", A_RLD, 16'h00FF);
    chkReg("R1 control reset", A_CTRL, 16'hF808);
  endtask

  task automatic test_high_at_reset;
    waitN(4);
    chkReg("R11 high input at release", A_STAT, 16'h0010);
    waitN(6);
    chkReg("R11 detected once", A_STAT, 16'h0010);
    wr(A_STAT, 16'h0000);
    waitN(5);
    chkReg("R11 still high no reset", A_STAT, 16'h0000);
    evtIrqA = 1'b0;
    waitN(4);
  endtask

  task automatic pulse_and_check(input string tag, input int which, input logic [15:0] exp);
    case (which)
      0: evtApm = 1'b1; 1: evtExt = 1'b1; 2: evtIrqA = 1'b1; default: evtIrqB = 1'b1;
    endcase
    @(negedge clk);
    evtApm = 1'b0; evtExt = 1'b0; evtIrqA = 1'b0; evtIrqB = 1'b0;
    @(negedge clk);
    chkReg({tag, " before latency"}, A_STAT, 16'h0000);
    @(negedge clk);
    chkReg({tag, " after latency"}, A_STAT, exp);
    wr(A_STAT, 16'h0000);
  endtask

  task automatic test_layout;
    pulse_and_check("R2 port write bit7", 0, 16'h0080);
    pulse_and_check("R2 external bit6", 1, 16'h0040);
    pulse_and_check("R2 irqA bit4", 2, 16'h0010);
    pulse_and_check("R2 irqB bit3", 3, 16'h0008);
  endtask

  task automatic test_write_bits;
    evtApm = 1'b1; evtIrqB = 1'b1;
    @(negedge clk);
    evtApm = 1'b0; evtIrqB = 1'b0;
    waitN(3);
    chkReg("R4 two bits set", A_STAT, 16'h0088);
    wr(A_STAT, 16'hFFFF);
    chkReg("R4 write ones no effect", A_STAT, 16'h0088);
    wr(A_STAT, 16'h0008);
    chkReg("R4 clear only bit7", A_STAT, 16'h0008);
    wr(A_STAT, 16'h0000);
    chkReg("R4 clear all", A_STAT, 16'h0000);
  endtask

  task automatic test_level;
    evtExt = 1'b1;
    waitN(4);
    chkReg("R3 level sets once", A_STAT, 16'h0040);
    wr(A_STAT, 16'h0000);
    waitN(6);
    chkReg("R3 held level no re-set", A_STAT, 16'h0000);
    evtExt = 1'b0;
    waitN(3);
    evtExt = 1'b1;
    waitN(4);
    chkReg("R3 new edge sets", A_STAT, 16'h0040);
    evtExt = 1'b0;
    wr(A_STAT, 16'h0000);
    waitN(3);
  endtask

  task automatic test_collision;
    evtApm = 1'b1;
    @(negedge clk);
    evtApm = 1'b0;
    waitN(3);
    chkReg("R5 setup bit7", A_STAT, 16'h0080);
    evtIrqB = 1'b1;
    waitN(2);
    wr(A_STAT, 16'h0000);   // lands on the same edge as the irqB set
    chkReg("R5 set beats clear", A_STAT, 16'h0008);
    evtIrqB = 1'b0;
    wr(A_STAT, 16'h0000);
    chkReg("R5 cleanup", A_STAT, 16'h0000);
    waitN(3);
  endtask

  task automatic test_disabled;
    wr(A_CTRL, 16'h8008);
    evtIrqA = 1'b1;
    @(negedge clk);
    evtIrqA = 1'b0;
    waitN(4);
    chkReg("R6 disabled irqA ignored", A_STAT, 16'h0000);
    evtApm = 1'b1;
    @(negedge clk);
    evtApm = 1'b0;
    waitN(4);
    chkReg("R6 enabled bit still sets", A_STAT, 16'h0080);
    wr(A_CTRL, 16'hF808);
  endtask

  task automatic test_smi;
    chk("R7 gate off smiN high", {15'h0, smiN}, 16'h0001);
    wr(A_CTRL, 16'hF809);
    chk("R7 gate on smiN low", {15'h0, smiN}, 16'h0000);
    wr(A_CTRL, 16'h7809);
    chk("R7 enable off smiN high", {15'h0, smiN}, 16'h0001);
    chkReg("R7 status kept without enable", A_STAT, 16'h0080);
    wr(A_CTRL, 16'hF809);
    chk("R7 re-enable smiN low", {15'h0, smiN}, 16'h0000);
    wr(A_STAT, 16'h0000);
    chk("R7 cleared smiN high", {15'h0, smiN}, 16'h0001);
    wr(A_CTRL, 16'hF808);
  endtask

  task automatic test_timer;
    wr(A_RLD, 16'h0003);
    wr(A_CTRL, 16'hF800);
    waitN(2);
    chkReg("R8 not yet expired", A_STAT, 16'h0000);
    waitN(1);
    chkReg("R8 expiry after reload ticks", A_STAT, 16'h0020);
    wr(A_STAT, 16'h0000);
    waitN(1);
    chkReg("R8 cleared mid period", A_STAT, 16'h0000);
    waitN(1);
    chkReg("R8 second expiry one period later", A_STAT, 16'h0020);
    tickEn = 1'b0;
    wr(A_STAT, 16'h0000);
    waitN(10);
    chkReg("R8 no ticks no expiry", A_STAT, 16'h0000);
    wr(A_CTRL, 16'hF808);
    tickEn = 1'b1;
  endtask

  task automatic test_reload;
    wr(A_RLD, 16'h0005);
    chkReg("R9 readback", A_RLD, 16'h0005);
    wr(A_CTRL, 16'hF800);
    wr(A_RLD, 16'h0009);
    chkReg("R9 write while running ignored", A_RLD, 16'h0005);
    wr(A_CTRL, 16'hF808);
    wr(A_STAT, 16'h0000);
    wr(A_RLD, 16'h0000);
    chkReg("R9 zero stored as one", A_RLD, 16'h0001);
    waitN(1);
    wr(A_CTRL, 16'hF800);
    waitN(1);
    chkReg("R9 one-tick period", A_STAT, 16'h0020);
    wr(A_CTRL, 16'hF808);
    wr(A_STAT, 16'h0000);
    chkReg("R9 cleanup", A_STAT, 16'h0000);
  endtask

  task automatic test_stop;
    wr(A_RLD, 16'h0004);
    waitN(1);
    wr(A_CTRL, 16'hF800);
    waitN(2);
    wr(A_CTRL, 16'hF808);
    waitN(10);
    chkReg("R10 stopped no expiry", A_STAT, 16'h0000);
    wr(A_CTRL, 16'hF800);
    waitN(3);
    chkReg("R10 restart full period pending", A_STAT, 16'h0000);
    waitN(1);
    chkReg("R10 restart full period expiry", A_STAT, 16'h0020);
    wr(A_CTRL, 16'hF808);
    wr(A_STAT, 16'h0000);
  endtask

  initial begin
    waitN(3);
    test_reset;
    rstN = 1'b1;
    test_high_at_reset;
    test_layout;
    test_write_bits;
    test_level;
    test_collision;
    test_disabled;
    test_smi;
    test_timer;
    test_reload;
    test_stop;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule